// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This block compares two floating-point operands of one precision (single or double, fixed by a parameter) and turns the comparison into one boolean condition bit. A 4-bit predicate code picks the condition. Its low three bits form a mask over three relations: unordered, equal and less-than. The condition is true when any relation that the mask selects holds between the two operands. The top bit of the code selects the signaling variant of the compare.

Each accepted compare produces a one-cycle write strobe for a bank of eight condition codes. The strobe carries the 3-bit index of the target code and the computed condition value. The same cycle carries an invalid-operation report. The condition-code bank and the status register that keeps exception flags sit outside this block; they consume the strobe and the report.

The operands are classified as NaN, signaling NaN or zero. Zeros of either sign are treated as equal. Ordered operands are then ranked by sign and magnitude. When both operands are negative the magnitude order is reversed.

Top module: `fpcmp_unit`

## Requirements
- R1: One clock edge after an edge at which `in_valid` is high, `cc_we` is high for exactly that cycle and `cc_sel` equals the `cc_idx` that was presented.
- R2: The condition result is `(pred[0] & unordered) | (pred[1] & equal) | (pred[2] & less)`. Less means operand A is below operand B. Mask code 0 therefore always gives false, and code 7 is false only when A is greater than B.
- R3: An operand whose exponent field is all ones and whose fraction is non-zero is a NaN. Any compare that involves a NaN is unordered: it is neither equal nor less.
- R4: Positive zero (all bits 0) and negative zero (only the sign bit set) compare equal, and neither is less than the other.
- R5: Ordered operands are ranked by sign and magnitude. Every negative value is below every positive value. Between two negatives the larger magnitude is lower. Infinities (exponent all ones, fraction zero) sit at the two ends of the order.
- R6: When `pred[3]` is 1 (signaling compare), `exc_invalid` is raised together with the result whenever either operand is a NaN of any kind.
- R7: When `pred[3]` is 0 (quiet compare), `exc_invalid` is raised only when an operand is a signaling NaN: a NaN whose most significant fraction bit is 0.
- R8: In a cycle that follows an edge without `in_valid`, `cc_we` and `exc_invalid` are low, and `cc_value` and `cc_sel` keep their previous values.
- R9: Synchronous active-high reset clears `cc_we`, `cc_sel`, `cc_value` and `exc_invalid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A compare request is presented this cycle |
| op_a | input | W (32 or 64) | Raw bit pattern of operand A |
| op_b | input | W (32 or 64) | Raw bit pattern of operand B |
| pred | input | 4 | Bit 3 selects signaling; bits 2..0 select the less, equal and unordered relations |
| cc_idx | input | 3 | Index of the condition code to write |
| cc_we | output | 1 | Condition-code write strobe |
| cc_sel | output | 3 | Index of the condition code being written |
| cc_value | output | 1 | Condition result |
| exc_invalid | output | 1 | Invalid-operation report for this compare |

## Verification
A pool of special values is swept exhaustively in pairs through all sixteen predicate codes. The pool holds both zeros, values of both signs and several magnitudes, a denormal, both infinities, a quiet NaN and a signaling NaN. The zero pairs separate a plain bit comparison from correct zero equality. Same-sign negative pairs expose a missing reversal of the magnitude order. The NaN pairs with quiet and signaling codes distinguish the two invalid rules. Random bit patterns are then interleaved with idle cycles, which shows that the result registers hold their values when no compare is presented.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    localparam int SGL_EXP_W = 8;
    localparam int DBL_EXP_W = 11;

    typedef struct packed {
        logic nan;
        logic snan;
        logic zero;
    } fp_class_t;

    typedef struct packed {
        logic lt;
        logic eq;
        logic un;
    } fp_rel_t;

    typedef enum logic [1:0] {
        MASK_UN = 2'd0,
        MASK_EQ = 2'd1,
        MASK_LT = 2'd2
    } mask_bit_e;

    function automatic logic rel_select(input fp_rel_t r, input logic [2:0] mask);
        return (mask[MASK_UN] & r.un) | (mask[MASK_EQ] & r.eq) | (mask[MASK_LT] & r.lt);
    endfunction

    function automatic logic invalid_rule(input logic signaling, input fp_class_t a,
                                          input fp_class_t b);
        return signaling ? (a.nan | b.nan) : (a.snan | b.snan);
    endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
    import fpcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] value,
    output fp_class_t             cls
);
    localparam int W = EXP_W + FRAC_W + 1;

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;

    assign expo = value[W-2 -: EXP_W];
    assign frac = value[FRAC_W-1:0];

    always_comb begin
        cls.nan  = (&expo) & (|frac);
        cls.snan = (&expo) & (|frac) & ~frac[FRAC_W-1];
        cls.zero = ~(|expo) & ~(|frac);
    end

    always_comb begin
        a_r7_snan_is_nan: assert (!cls.snan || cls.nan);
    end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  fp_class_t    ca,
    input  fp_class_t    cb,
    output fp_rel_t      rel
);
    logic         sa, sb;
    logic [W-2:0] ma, mb;
    logic         mag_lt, mag_gt, ord_lt;

    assign sa = a[W-1];
    assign sb = b[W-1];
    assign ma = a[W-2:0];
    assign mb = b[W-2:0];
    assign mag_lt = ma < mb;
    assign mag_gt = ma > mb;

    always_comb begin
        if (sa != sb) ord_lt = sa;
        else if (sa)  ord_lt = mag_gt;
        else          ord_lt = mag_lt;
    end

    always_comb begin
        rel.un = ca.nan | cb.nan;
        rel.eq = ~rel.un & ((ca.zero & cb.zero) | (a == b));
        rel.lt = ~rel.un & ~rel.eq & ord_lt;
    end

    always_comb begin
        a_r3_rel_exclusive: assert ($onehot0({rel.un, rel.eq, rel.lt}));
    end

endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
    import fpcmp_pkg::*;
#(
    parameter bit IS_DOUBLE = 1'b0,
    localparam int EXP_W  = IS_DOUBLE ? DBL_EXP_W : SGL_EXP_W,
    localparam int W      = IS_DOUBLE ? 64 : 32,
    localparam int FRAC_W = W - 1 - EXP_W,
    localparam int CC_N   = 8,
    localparam int CC_W   = $clog2(CC_N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [W-1:0]    op_a,
    input  logic [W-1:0]    op_b,
    input  logic [3:0]      pred,
    input  logic [CC_W-1:0] cc_idx,
    output logic            cc_we,
    output logic [CC_W-1:0] cc_sel,
    output logic            cc_value,
    output logic            exc_invalid
);
    logic [W-1:0] ops [2];
    fp_class_t    cls [2];
    fp_rel_t      rel;
    logic         result_now, invalid_now;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar g = 0; g < 2; g++) begin : g_cls
        fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .value(ops[g]),
            .cls  (cls[g])
        );
    end

    fpcmp_order #(.W(W)) u_ord (
        .a  (op_a),
        .b  (op_b),
        .ca (cls[0]),
        .cb (cls[1]),
        .rel(rel)
    );

    assign result_now  = rel_select(rel, pred[2:0]);
    assign invalid_now = invalid_rule(pred[3], cls[0], cls[1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_we       <= 1'b0;
            cc_sel      <= '0;
            cc_value    <= 1'b0;
            exc_invalid <= 1'b0;
        end else begin
            cc_we       <= in_valid;
            exc_invalid <= in_valid & invalid_now;
            if (in_valid) begin
                cc_sel   <= cc_idx;
                cc_value <= result_now;
            end
        end
    end

    a_r1_strobe: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (cc_we && cc_sel == $past(cc_idx)));

    a_r8_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!cc_we && !exc_invalid && $stable(cc_value)));

    a_r2_false_code: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pred[2:0] == 3'd0) |=> !cc_value);

    a_r4_zero_equal: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cls[0].zero && cls[1].zero && pred[1]) |=> cc_value);

    a_r6_signaling: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pred[3] && (cls[0].nan || cls[1].nan)) |=> exc_invalid);

endmodule

// File: tb/sim_fpcmp_unit.sv
module sim_fpcmp_unit;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic [3:0]  pred = '0;
    logic [2:0]  cc_idx = '0;
    logic        cc_we, cc_value, exc_invalid;
    logic [2:0]  cc_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic       exp_we = 1'b0, exp_val = 1'b0, exp_inv = 1'b0;
    logic [2:0] exp_sel = '0;
    bit         prev_idle = 1'b1;
    string      vtag = "R9", itag = "R9", ptag = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    fpcmp_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .pred(pred), .cc_idx(cc_idx), .cc_we(cc_we), .cc_sel(cc_sel),
        .cc_value(cc_value), .exc_invalid(exc_invalid)
    );

    function automatic bit is_nan(logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic bit is_snan(logic [31:0] x);
        return is_nan(x) && !x[22];
    endfunction

    function automatic longint key(logic [31:0] x);
        longint m = longint'(x[30:0]);
        return x[31] ? -m : m;
    endfunction

    task automatic check1(string tag, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %0b expected %0b", tag, what, got, exp);
        end
    endtask

    task automatic compare_outputs();
        string t1 = prev_idle ? "R8" : "R1";
        string tv = prev_idle ? "R8" : vtag;
        string ti = prev_idle ? "R8" : itag;
        check1(t1, "cc_we", cc_we, exp_we);
        checks++;
        if (cc_sel !== exp_sel) begin
            fails++;
            $display("FAIL %s cc_sel got %0d expected %0d", t1, cc_sel, exp_sel);
        end
        check1(tv, "cc_value", cc_value, exp_val);
        check1(ti, "exc_invalid", exc_invalid, exp_inv);
    endtask

    task automatic cycle(bit v, logic [31:0] a, logic [31:0] b, logic [3:0] p, logic [2:0] i);
        bit un, eq, lt;
        @(negedge clk);
        compare_outputs();
        un = is_nan(a) || is_nan(b);
        eq = !un && key(a) == key(b);
        lt = !un && key(a) < key(b);
        if (v) begin
            exp_we  = 1'b1;
            exp_sel = i;
            exp_val = (p[0] && un) || (p[1] && eq) || (p[2] && lt);
            exp_inv = p[3] ? un : (is_snan(a) || is_snan(b));
        end else begin
            exp_we  = 1'b0;
            exp_inv = 1'b0;
        end
        prev_idle = !v;
        in_valid = v; op_a = a; op_b = b; pred = p; cc_idx = i;
    endtask

    logic [31:0] pool [12];

    initial begin
        pool[0]  = 32'h0000_0000;
        pool[1]  = 32'h8000_0000;
        pool[2]  = 32'h3F80_0000;
        pool[3]  = 32'hBF80_0000;
        pool[4]  = 32'h4000_0000;
        pool[5]  = 32'hC000_0000;
        pool[6]  = 32'h0000_0001;
        pool[7]  = 32'h7F80_0000;
        pool[8]  = 32'hFF80_0000;
        pool[9]  = 32'h7FC0_0000;
        pool[10] = 32'h7F80_0001;
        pool[11] = 32'hFFA0_0000;

        // R9: reset state
        repeat (3) @(negedge clk);
        compare_outputs();
        rst = 1'b0;

        // R2 R3 R4 R5 R6 R7: exhaustive pool sweep over all predicate codes
        for (int x = 0; x < 12; x++) begin
            for (int y = 0; y < 12; y++) begin
                for (int p = 0; p < 16; p++) begin
                    if (x >= 9 || y >= 9) begin
                        vtag = "R3"; itag = (p >= 8) ? "R6" : "R7";
                    end else if (x <= 1 && y <= 1) begin
                        vtag = "R4"; itag = "R7";
                    end else begin
                        vtag = (p[2:0] == 0) ? "R2" : "R5"; itag = "R7";
                    end
                    cycle(1'b1, pool[x], pool[y], 4'(p), 3'(x + y + p));
                end
            end
            cycle(1'b0, 32'hDEAD_BEEF, 32'h0, 4'hF, 3'd5);
        end

        // R8 and R5: random patterns with interleaved idle cycles
        vtag = "R5"; itag = "R7";
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a, b;
            a = ($urandom % 3 == 0) ? pool[$urandom % 12] : $urandom;
            b = ($urandom % 3 == 0) ? pool[$urandom % 12] : $urandom;
            if ($urandom % 2 == 0) b = {a[31], a[30:0] ^ 31'($urandom % 4)};
            cycle(($urandom % 4) != 0, a, b, 4'($urandom), 3'($urandom));
        end
        cycle(1'b0, '0, '0, '0, '0);
        cycle(1'b0, '0, '0, '0, '0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog got hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule